// File: doc/BRIEF.md
# Two-Bit Wrapping Burst Address Generator

This block supplies the two least significant address bits for a four-beat memory burst. A load strobe captures a two-bit start address and the ordering mode. Each advance strobe then moves the burst one beat forward. The generated address always stays inside the aligned group of four locations and never carries into the upper address bits. The upper address bits, the storage array and the data path belong to the surrounding logic.

Two orderings are available. In linear order, each step adds one modulo four. In interleaved order, each beat address is the start address XOR the beat number. The ordering mode is sampled only when a burst is loaded. Any mode level other than a driven low, including an undriven pin, selects interleaved order, and interleaved order is also the ordering held after reset.

Top module: `burst_addr_gen`

## Requirements
- R1: During and after a synchronous reset, with no load since, `burst_addr` is 2'b00 and `last_beat` is 0.
- R2: On the cycle after `load` is high, `burst_addr` equals the `start_addr` presented with that load, and `last_beat` is 0.
- R3: When the held order is linear (`mode` was 0 at load), each advance without load makes `burst_addr` the previous value plus one, modulo four. For example, start 01 gives 01, 10, 11, 00.
- R4: When the held order is interleaved (`mode` was 1 or undriven at load), `burst_addr` on beat k (k = 0..3) equals the start address XOR k. For example, start 10 gives 10, 11, 00, 01.
- R5: When `load` and `advance` are high in the same cycle, the load wins: the burst restarts at beat 0 with the new start address.
- R6: `last_beat` is 1 exactly while the burst is on its fourth beat (beat index 3).
- R7: An advance taken on the fourth beat wraps back to beat 0, so `burst_addr` returns to the start address and `last_beat` falls. A burst visits four distinct addresses.
- R8: `mode` is sampled only at load. A change of `mode` during a burst has no effect on `burst_addr` or `last_beat`.
- R9: In a cycle with neither `load` nor `advance`, `burst_addr` and `last_beat` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures `start_addr` and `mode`, and restarts at beat 0 |
| start_addr | input | 2 | Starting low address bits of the burst |
| advance | input | 1 | Steps the burst by one beat |
| mode | input | 1 | 0 = linear order; 1 or undriven = interleaved order |
| burst_addr | output | 2 | Current low address bits of the burst |
| last_beat | output | 1 | High while on the fourth beat |

## Verification
The embedded assertions check the following on every clock:
- the reset state;
- seeding on load, including when advance is also high;
- the plus-one step in linear order;
- the third-to-fourth beat flag rise and the wrap back to the start;
- holding during idle cycles;
- the stability of the held ordering between loads.

The interleaved XOR pattern, the four-distinct-address property over whole bursts, and the immunity to mode toggles in mid-burst appear only across multi-cycle scenarios. The bench checks these against its behavioural model for every start value in both orders and under a pseudo-random stream of strobes.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Anything other than a clean low (including an undriven pin) means interleave.
    function automatic order_e decode_order(input logic m);
        return (m === 1'b0) ? ORD_LINEAR : ORD_INTERLEAVE;
    endfunction

    function automatic logic [BEAT_W-1:0] beat_address(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input order_e            ord
    );
        logic [BEAT_W-1:0] r;
        if (ord == ORD_LINEAR) r = start + beat;
        else                   r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_seed_reg.sv
module burst_seed_reg
    import burst_pkg::*;
#(
    parameter int W = BEAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    input  logic         mode_i,
    output logic [W-1:0] start_q,
    output order_e       ord_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ord_q   <= ORD_INTERLEAVE;
        end else if (load_i) begin
            start_q <= start_i;
            ord_q   <= decode_order(mode_i);
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int W = BEAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         adv_i,
    output logic [W-1:0] beat_q,
    output logic         last_o
);

    always_ff @(posedge clk) begin
        if (rst)         beat_q <= '0;
        else if (load_i) beat_q <= '0;
        else if (adv_i)  beat_q <= beat_q + 1'b1;
    end

    assign last_o = (beat_q == {W{1'b1}});

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
#(
    parameter int W = BEAT_W
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    input  order_e       ord_i,
    output logic [W-1:0] addr_o
);

    always_comb addr_o = beat_address(start_i, beat_i, ord_i);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int W = BEAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] start_addr,
    input  logic         advance,
    input  logic         mode,
    output logic [W-1:0] burst_addr,
    output logic         last_beat
);

    logic [W-1:0] start_q;
    logic [W-1:0] beat_q;
    order_e       ord_q;

    burst_seed_reg #(.W(W)) u_seed (
        .clk(clk), .rst(rst), .load_i(load), .start_i(start_addr),
        .mode_i(mode), .start_q(start_q), .ord_q(ord_q)
    );

    burst_beat_ctr #(.W(W)) u_beat (
        .clk(clk), .rst(rst), .load_i(load), .adv_i(advance),
        .beat_q(beat_q), .last_o(last_beat)
    );

    burst_addr_map #(.W(W)) u_map (
        .start_i(start_q), .beat_i(beat_q), .ord_i(ord_q), .addr_o(burst_addr)
    );

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (burst_addr == '0 && !last_beat)); // R1
    AST_LOAD_SEEDS: assert property (@(posedge clk) disable iff (rst)
        load |=> (burst_addr == $past(start_addr) && !last_beat)); // R2
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && ord_q == ORD_LINEAR) |=> (burst_addr == W'($past(burst_addr) + 1'b1))); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load && advance) |=> (beat_q == '0)); // R5
    AST_LAST_RISES: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && beat_q == W'(BEATS - 2)) |=> last_beat); // R6
    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && last_beat) |=> (burst_addr == $past(start_q) && !last_beat)); // R7
    AST_ORDER_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ord_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> ($stable(burst_addr) && $stable(last_beat))); // R9

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [1:0] start_addr = 2'b00;
    logic       advance = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] burst_addr;
    logic       last_beat;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural model state
    int ref_start = 0;
    int ref_beat  = 0;
    bit ref_lin   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    burst_addr_gen u_dut (
        .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
        .advance(advance), .mode(mode), .burst_addr(burst_addr), .last_beat(last_beat)
    );

    function automatic int model_addr();
        if (ref_lin) return (ref_start + ref_beat) % 4;
        return ref_start ^ ref_beat;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ref_start = 0; ref_beat = 0; ref_lin = 1'b0;
        end else if (load) begin
            ref_start = int'(start_addr); ref_beat = 0; ref_lin = (mode == 1'b0);
        end else if (advance) begin
            ref_beat = (ref_beat + 1) % 4;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            total++;
            if (int'(burst_addr) != model_addr() || last_beat != (ref_beat == 3)) begin
                bad++;
                $display("FAIL %s: addr=%0d last=%0d expected addr=%0d last=%0d",
                         cur_req, burst_addr, last_beat, model_addr(), (ref_beat == 3));
            end
        end
    end

    task automatic step(input bit ld, input bit adv, input logic [1:0] st, input bit md);
        @(negedge clk);
        load = ld; advance = adv; start_addr = st; mode = md;
    endtask

    task automatic burst(input logic [1:0] st, input bit md, input int advs);
        step(1'b1, 1'b0, st, md);
        for (int i = 0; i < advs; i++) step(1'b0, 1'b1, 2'b00, md);
        step(1'b0, 1'b0, 2'b00, md);
    endtask

    initial begin
        bit [7:0] lfsr;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0, 2'b00, 1'b0);
        step(1'b0, 1'b0, 2'b00, 1'b0);

        cur_req = "R3";  burst(2'b01, 1'b0, 5);   // 01 10 11 00 01
        cur_req = "R4";  burst(2'b10, 1'b1, 5);   // 10 11 00 01 10
        cur_req = "R2";  burst(2'b11, 1'b0, 0);
        cur_req = "R5";
        step(1'b1, 1'b0, 2'b01, 1'b1);
        step(1'b0, 1'b1, 2'b00, 1'b1);
        step(1'b1, 1'b1, 2'b11, 1'b0);
        step(1'b0, 1'b1, 2'b00, 1'b0);
        cur_req = "R6";  burst(2'b00, 1'b1, 3);
        cur_req = "R7";
        for (int s = 0; s < 4; s++) begin
            burst(2'(s), 1'b0, 4);
            burst(2'(s), 1'b1, 4);
        end
        cur_req = "R8";
        step(1'b1, 1'b0, 2'b01, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 2'b00, 1'(i));
        step(1'b1, 1'b0, 2'b11, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 2'b00, 1'(~i));
        cur_req = "R9";
        step(1'b1, 1'b0, 2'b10, 1'b0);
        step(1'b0, 1'b1, 2'b00, 1'b0);
        repeat (4) step(1'b0, 1'b0, 2'b00, 1'b1);
        cur_req = "R4";
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] & lfsr[3] & lfsr[6], lfsr[1] | lfsr[4], lfsr[3:2], lfsr[5]);
        end
        cur_req = "R1";
        @(negedge clk); rst = 1'b1; load = 1'b0; advance = 1'b1;
        step(1'b0, 1'b1, 2'b00, 1'b0);
        @(negedge clk); rst = 1'b0; advance = 1'b0;
        step(1'b0, 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        #1 finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule